// File: doc/BRIEF.md
# Memory Sleep-Mode Sequencer

This block sequences a synchronous memory into and out of a low-power sleep state. A sleep request arrives asynchronously and active high. The block passes it through a flop synchroniser and then counts a fixed entry latency before it reports that the memory is asleep. When the request drops, it counts a fixed wake-up latency before it accepts ordinary traffic again. For the whole span from the first gated cycle to the end of wake-up, the block closes the gate on the memory's other inputs and forces the data outputs to high impedance. The memory therefore behaves as deselected, and its contents and registers are left untouched.

The memory core supplies a flag that is high while a read or write is still in flight. If gating starts while that flag is high, the operation cannot be guaranteed to finish, so the block raises a one-cycle error pulse. A request that falls away before the entry count has finished abandons the entry. In that case the low-power indication never asserts, and the block runs the normal wake-up count before it reopens the gate.

Top module: `snooze_seq`

## Requirements
- R1: After reset, `in_gate_en` is 1 and `out_hiz`, `low_power` and `pend_err` are all 0.
- R2: The request is sampled high at a rising edge E, and it stays high. `in_gate_en` falls after edge E+2 and `low_power` rises after edge E+4: two synchroniser stages, then a two-cycle entry count.
- R3: From sleep, the request is sampled low at edge E, and it stays low. `low_power` falls after edge E+2 and `in_gate_en` returns to 1 after edge E+4: a two-cycle wake-up count.
- R4: While gated, `in_gate_en` is 0. Neither `op_pending` nor any other input besides the request changes the block's outputs.
- R5: `out_hiz` is 1 in exactly the cycles in which `in_gate_en` is 0. This covers the first gated cycle through the end of the wake-up count.
- R6: `pend_err` is high for exactly the one cycle in which gating begins, and only if `op_pending` was 1 at the edge that closed the gate.
- R7: If the synchronised request drops before the entry count finishes, entry is cancelled. `low_power` stays 0, and the gate reopens after the two-cycle wake-up count.
- R8: If the synchronised request rises again during the wake-up count, entry restarts from the beginning of its count. The gate stays closed throughout.
- R9: `low_power` is only ever 1 while `in_gate_en` is 0, and it asserts only after at least one gated cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Asynchronous active-high sleep request |
| op_pending | input | 1 | High while a memory operation is in flight |
| in_gate_en | output | 1 | 1 = memory inputs accepted, 0 = gated off |
| out_hiz | output | 1 | Forces memory data outputs to high impedance |
| low_power | output | 1 | Memory is in the sleep state |
| pend_err | output | 1 | One-cycle pulse: gating began with an operation in flight |

## Verification
The bench builds the block with two synchroniser stages and two-cycle entry and wake-up counts. With counts this short, random request pulses of one to four cycles land on every point of the sequence. That includes a cancel at each entry count value and a re-request at each wake-up count value. Directed runs measure the exact edge counts for entry and exit. They also drive a pending operation at the moment gating begins and while gated.

// File: rtl/snooze_pkg.sv
package snooze_pkg;

    typedef enum logic [1:0] {
        PH_AWAKE = 2'd0,
        PH_ENTER = 2'd1,
        PH_SLEEP = 2'd2,
        PH_WAKE  = 2'd3
    } phase_e;

endpackage

// File: rtl/snooze_sync.sv
module snooze_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                assign chain_d[g] = async_in;
            end else begin : g_rest
                assign chain_d[g] = chain_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/snooze_fsm.sv
module snooze_fsm
    import snooze_pkg::*;
#(
    parameter int ENTRY_CYCLES = 2,
    parameter int EXIT_CYCLES  = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_sync,
    input  logic   op_pending,
    output phase_e phase,
    output logic   err_pulse
);
    localparam int MAXC  = (ENTRY_CYCLES > EXIT_CYCLES) ? ENTRY_CYCLES : EXIT_CYCLES;
    localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CNT_W-1:0] ENTRY_LAST = CNT_W'(ENTRY_CYCLES - 1);
    localparam logic [CNT_W-1:0] EXIT_LAST  = CNT_W'(EXIT_CYCLES - 1);

    typedef struct packed {
        phase_e         ph;
        logic [CNT_W-1:0] cnt;
        logic           err;
    } fsm_t;

    fsm_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        unique case (st_q.ph)
            PH_AWAKE: begin
                if (req_sync) begin
                    st_d.ph  = PH_ENTER;
                    st_d.cnt = '0;
                    st_d.err = op_pending;
                end
            end
            PH_ENTER: begin
                if (!req_sync) begin
                    st_d.ph  = PH_WAKE;
                    st_d.cnt = '0;
                end else if (st_q.cnt == ENTRY_LAST) begin
                    st_d.ph  = PH_SLEEP;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_SLEEP: begin
                if (!req_sync) begin
                    st_d.ph  = PH_WAKE;
                    st_d.cnt = '0;
                end
            end
            PH_WAKE: begin
                if (req_sync) begin
                    st_d.ph  = PH_ENTER;
                    st_d.cnt = '0;
                end else if (st_q.cnt == EXIT_LAST) begin
                    st_d.ph  = PH_AWAKE;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.ph = PH_AWAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph  <= PH_AWAKE;
            st_q.cnt <= '0;
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase     = st_q.ph;
    assign err_pulse = st_q.err;
endmodule

// File: rtl/snooze_seq.sv
module snooze_seq
    import snooze_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int ENTRY_CYCLES = 2,
    parameter int EXIT_CYCLES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic op_pending,
    output logic in_gate_en,
    output logic out_hiz,
    output logic low_power,
    output logic pend_err
);
    logic   req_s;
    phase_e phase;

    snooze_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sleep_req),
        .sync_out (req_s)
    );

    snooze_fsm #(
        .ENTRY_CYCLES (ENTRY_CYCLES),
        .EXIT_CYCLES  (EXIT_CYCLES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_sync   (req_s),
        .op_pending (op_pending),
        .phase      (phase),
        .err_pulse  (pend_err)
    );

    assign in_gate_en = (phase == PH_AWAKE);
    assign out_hiz    = (phase != PH_AWAKE);
    assign low_power  = (phase == PH_SLEEP);
endmodule

// File: rtl/snooze_seq_chk.sv
module snooze_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic in_gate_en,
    input logic out_hiz,
    input logic low_power,
    input logic pend_err
);
    // R9
    lp_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_power |-> (!in_gate_en && out_hiz));

    // R9
    lp_after_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_power) |-> $past(out_hiz));

    // R3
    wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(low_power) |-> (out_hiz && !in_gate_en));

    // R3
    no_direct_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_gate_en) |-> !$past(low_power));

    // R6
    err_at_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_err |-> ($fell(in_gate_en) && !low_power));

    // R5
    hiz_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_hiz != in_gate_en);
endmodule

bind snooze_seq snooze_seq_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_gate_en (in_gate_en),
    .out_hiz    (out_hiz),
    .low_power  (low_power),
    .pend_err   (pend_err)
);

// File: tb/test_snooze_seq.sv
module test_snooze_seq;
    localparam int ENTRY = 2;
    localparam int EXIT  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0;
    logic op_pending = 1'b0;
    logic in_gate_en, out_hiz, low_power, pend_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    snooze_seq i_snooze_seq (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .op_pending(op_pending),
        .in_gate_en(in_gate_en), .out_hiz(out_hiz), .low_power(low_power), .pend_err(pend_err)
    );

    // expected behaviour: 0 awake, 1 entering, 2 asleep, 3 waking
    int  m_ph = 0;
    int  m_cnt = 0;
    bit  m_err = 0;
    bit  m_s1 = 0, m_s2 = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_err = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            int ph_n; int cnt_n; bit err_n;
            ph_n = m_ph; cnt_n = m_cnt; err_n = 0;
            case (m_ph)
                0: if (m_s2) begin ph_n = 1; cnt_n = 0; err_n = op_pending; end
                1: if (!m_s2) begin ph_n = 3; cnt_n = 0; end
                   else if (m_cnt == ENTRY-1) begin ph_n = 2; cnt_n = 0; end
                   else cnt_n = m_cnt + 1;
                2: if (!m_s2) begin ph_n = 3; cnt_n = 0; end
                default: if (m_s2) begin ph_n = 1; cnt_n = 0; end
                   else if (m_cnt == EXIT-1) begin ph_n = 0; cnt_n = 0; end
                   else cnt_n = m_cnt + 1;
            endcase
            m_ph = ph_n; m_cnt = cnt_n; m_err = err_n;
            m_s2 = m_s1; m_s1 = sleep_req;
        end
    end

    function automatic bit exp_gate(int ph);  return ph == 0; endfunction
    function automatic bit exp_lp(int ph);    return ph == 2; endfunction

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R4 in_gate_en", in_gate_en, exp_gate(m_ph));
        chk("R5 out_hiz", out_hiz, !exp_gate(m_ph));
        chk("R2/R3/R7 low_power", low_power, exp_lp(m_ph));
        chk("R6 pend_err", pend_err, m_err);
    endtask

    task automatic step(bit req, bit op);
        @(negedge clk);
        compare_all();
        sleep_req = req;
        op_pending = op;
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int k;
        int seen_lp;
        int seen_gate;
        int seen_open;
        bit any_lp;
        bit any_err;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 gate", in_gate_en, 1'b1);
        chk("R1 hiz", out_hiz, 1'b0);
        chk("R1 lp", low_power, 1'b0);
        chk("R1 err", pend_err, 1'b0);
        rst_n = 1'b1;
        repeat (3) step(0, 0);

        // R2 entry timing, with op pending at gate close -> R6
        @(negedge clk); sleep_req = 1'b1; op_pending = 1'b1;
        seen_lp = 0; seen_gate = 0; any_err = 0;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            compare_all();
            if (!in_gate_en && seen_gate == 0) seen_gate = i;
            if (low_power && seen_lp == 0) seen_lp = i;
            if (pend_err) any_err = 1;
        end
        chk("R2 gate closes after E+2", seen_gate == 3, 1'b1);
        chk("R2 low_power after E+4", seen_lp == 5, 1'b1);
        chk("R6 error pulse seen", any_err, 1'b1);

        // R4 op_pending toggling while asleep: no error, outputs unchanged
        any_err = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            op_pending = i[0];
            if (pend_err) any_err = 1;
            chk("R4 asleep lp held", low_power, 1'b1);
        end
        chk("R4 no error while gated", any_err, 1'b0);

        // R3 exit timing
        @(negedge clk); sleep_req = 1'b0; op_pending = 1'b0;
        seen_lp = 0; seen_open = 0;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            compare_all();
            if (!low_power && seen_lp == 0) seen_lp = i;
            if (in_gate_en && seen_open == 0) seen_open = i;
        end
        chk("R3 low_power falls after E+2", seen_lp == 3, 1'b1);
        chk("R3 gate opens after E+4", seen_open == 5, 1'b1);

        // R7 cancel: short pulses of 1 and 2 cycles never reach sleep
        for (int w = 1; w <= 2; w++) begin
            any_lp = 0;
            @(negedge clk); sleep_req = 1'b1;
            for (int i = 0; i < w; i++) begin @(negedge clk); compare_all(); end
            sleep_req = 1'b0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk); compare_all();
                if (low_power) any_lp = 1;
            end
            chk("R7 cancelled entry no low_power", any_lp, 1'b0);
            chk("R7 gate reopened", in_gate_en, 1'b1);
        end

        // R8 re-request during wake: gate stays closed, sleep re-entered
        @(negedge clk); sleep_req = 1'b1;
        for (int i = 0; i < 8; i++) step(1, 0);
        step(0, 0);
        k = 0;
        for (int i = 0; i < 10; i++) begin
            step(1, 0);
            if (in_gate_en) k++;
        end
        chk("R8 gate never reopened", k == 0, 1'b1);
        chk("R8 asleep again", low_power, 1'b1);
        for (int i = 0; i < 8; i++) step(0, 0);

        // random mix
        begin
            int seed_dummy;
            bit r;
            seed_dummy = $urandom(32'h5EED);
            r = 0;
            for (int i = 0; i < 3000; i++) begin
                if (($urandom % 4) == 0) r = ~r;
                step(r, 1'($urandom % 2));
            end
        end
        for (int i = 0; i < 10; i++) step(0, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule